// File: doc/BRIEF.md
# Dual-Processor Interrupt Steering Controller

This block gathers up to 31 level-sensitive interrupt lines into a pending-status register and routes each line to one of two processors. Each processor has its own enable mask, and each processor gets one request output. A request is raised when any pending bit is also enabled in that processor's mask. Software reads and writes the masks and the status register over a simple 32-bit register bus. Every write to these registers uses the top data bit to choose between setting bits and clearing bits.

The block never enables a source for both processors at once. If a mask write leaves a source enabled in both masks, a sticky collision flag is raised. A read-only board information word reports the identity of the processor that is reading it. Unsupported accesses raise a sticky access-error flag.

Source line bit i feeds status bit i. Line bit 31 carries no state. Sources labelled in reversed order (label n) therefore sit at bit 31−n. Bus decoding resolves every access into one of four selections: SEL_MASK (with a processor index), SEL_STAT, SEL_INFO and SEL_NONE. Each access takes the decode transition for its address in the same cycle. No access sequence spans more than one cycle.

Top module: `irq_steer_top`

## Requirements
- R1: After reset, both masks, the status register, both request outputs, both error flags and the read data are 0.
- R2: A write to a processor mask (offset 0x0F0 for processor 0, 0x1F0 for processor 1) with bit 31 = 1 ORs the data bits 30..0 into the mask. With bit 31 = 0, the write clears every mask bit whose data bit is 1. Mask bit 31 always reads 0.
- R3: A write to the status register (offset 0x2F0) follows the same set/clear rule as R2. Status bit 31 always reads 0.
- R4: irq_o[n] is 1 exactly when (status AND mask n) is non-zero. The output is registered and changes one clock after the status or mask change.
- R5: After the two-flop synchroniser, a rising source line bit i (i ≤ 30) sets status bit i and a falling line clears it. Line bit 31 has no effect.
- R6: When a status write and a source edge hit the same status bit in one cycle, the written value wins for that bit.
- R7: If a mask write leaves any bit set in both masks, err_collide goes to 1 and stays 1 until reset.
- R8: A read of the information register (offset 0x3F0) returns the BOARD_INFO parameter with bit 25 replaced by bus_cpu_id.
- R9: A write to offset 0x3F0, or a read or write to any unlisted offset, sets the sticky err_access flag. An unlisted read returns 0.
- R10: bus_rdata is registered: it is valid the cycle after bus_re and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt source line field, asynchronous |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_cpu_id | input | 1 | Identity of the requesting processor |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_re |
| irq_o | output | 2 | Interrupt request per processor |
| err_collide | output | 1 | Sticky mask-overlap flag |
| err_access | output | 1 | Sticky unsupported-access flag |

## Verification
Set and clear writes are applied to masks that share no bit with the data. This separates an OR/AND-NOT update from a plain store. Writes of all ones show whether bit 31 is kept as state. The request outputs are sampled in the cycle just after a write and in the cycle after that, which separates registered timing from combinational timing. Status and masks are arranged so that only one processor matches, which catches swapped routing. A source edge is lined up with a clearing write to the same bit, which shows which of the two wins. The information word is read under both requester identities.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int REG_W     = 32;
    localparam int SC_BIT    = 31;
    localparam int ID_BIT    = 25;
    localparam int NCPU      = 2;
    localparam int CPU_IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1;
    localparam logic [REG_W-1:0] LIVE_BITS = {1'b0, {(REG_W-1){1'b1}}};

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_STAT,
        SEL_INFO
    } reg_sel_e;

    // Set/clear write: the selector bit picks OR-in or AND-NOT; bit 31 never holds state.
    function automatic logic [REG_W-1:0] apply_sc(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] wr);
        logic [REG_W-1:0] nx;
        if (wr[SC_BIT]) nx = cur | wr;
        else            nx = cur & ~wr;
        return nx & LIVE_BITS;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_steer_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int MASK_BASE   = 'h0F0,
    parameter int MASK_STRIDE = 'h100,
    parameter int STAT_OFF    = 'h2F0,
    parameter int INFO_OFF    = 'h3F0
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output reg_sel_e             sel_o,
    output logic [CPU_IDX_W-1:0] idx_o
);
    always_comb begin
        sel_o = SEL_NONE;
        idx_o = '0;
        for (int n = 0; n < NCPU; n++) begin
            if (addr_i == ADDR_W'(MASK_BASE + n * MASK_STRIDE)) begin
                sel_o = SEL_MASK;
                idx_o = CPU_IDX_W'(n);
            end
        end
        if (addr_i == ADDR_W'(STAT_OFF)) sel_o = SEL_STAT;
        if (addr_i == ADDR_W'(INFO_OFF)) sel_o = SEL_INFO;
    end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         req_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= |(status_i & mask_i);
    end
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int               ADDR_W      = 12,
    parameter int               SYNC_STAGES = 2,
    parameter logic [REG_W-1:0] BOARD_INFO  = 32'hA5C3_0F1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_cpu_id,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NCPU-1:0]   irq_o,
    output logic              err_collide,
    output logic              err_access
);
    reg_sel_e                        sel;
    logic [CPU_IDX_W-1:0]            idx;
    logic [NCPU-1:0][REG_W-1:0]      mask_q, mask_d;
    logic [REG_W-1:0]                stat_q, stat_d;
    logic [REG_W-1:0]                src_s, src_prev_q, rise, fall;
    logic                            wr_mask, wr_stat, collide_hit, acc_bad;

    irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .sel_o  (sel),
        .idx_o  (idx)
    );

    irq_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (src_s)
    );

    assign rise    = src_s & ~src_prev_q & LIVE_BITS;
    assign fall    = ~src_s & src_prev_q & LIVE_BITS;
    assign wr_mask = bus_we && (sel == SEL_MASK);
    assign wr_stat = bus_we && (sel == SEL_STAT);

    // Mask next state and overlap detection
    always_comb begin
        mask_d = mask_q;
        if (wr_mask) mask_d[idx] = apply_sc(mask_q[idx], bus_wdata);
        collide_hit = wr_mask && (|(mask_d[0] & mask_d[1]));
    end

    // Status next state: bus-written bits override source edges
    always_comb begin
        logic [REG_W-1:0] edge_nx, bus_nx, own;
        edge_nx = (stat_q | rise) & ~fall;
        bus_nx  = apply_sc(stat_q, bus_wdata);
        own     = wr_stat ? (bus_wdata & LIVE_BITS) : '0;
        stat_d  = ((bus_nx & own) | (edge_nx & ~own)) & LIVE_BITS;
    end

    always_comb begin
        acc_bad = 1'b0;
        unique case (sel)
            SEL_NONE: acc_bad = bus_we || bus_re;
            SEL_INFO: acc_bad = bus_we;
            SEL_MASK: acc_bad = 1'b0;
            SEL_STAT: acc_bad = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '0;
            stat_q      <= '0;
            src_prev_q  <= '0;
            err_collide <= 1'b0;
            err_access  <= 1'b0;
        end else begin
            mask_q      <= mask_d;
            stat_q      <= stat_d;
            src_prev_q  <= src_s;
            err_collide <= err_collide | collide_hit;
            err_access  <= err_access | acc_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            unique case (sel)
                SEL_MASK: bus_rdata <= mask_q[idx];
                SEL_STAT: bus_rdata <= stat_q;
                SEL_INFO: begin
                    bus_rdata         <= BOARD_INFO;
                    bus_rdata[ID_BIT] <= bus_cpu_id;
                end
                SEL_NONE: bus_rdata <= '0;
            endcase
        end
    end

    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_req
            irq_req_gen #(.W(REG_W)) u_req (
                .clk      (clk),
                .rst_n    (rst_n),
                .status_i (stat_q),
                .mask_i   (mask_q[c]),
                .req_o    (irq_o[c])
            );
        end
    endgenerate
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] mask0,
    input logic [31:0] mask1,
    input logic [31:0] stat,
    input logic [1:0]  irq,
    input logic        err_collide,
    input logic        err_access
);
    AST_MASK_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mask0[31] && !mask1[31]); // R2
    AST_STAT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[31]); // R3
    AST_IRQ0_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq[0] == $past(|(stat & mask0)))); // R4
    AST_IRQ1_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq[1] == $past(|(stat & mask1)))); // R4
    AST_COLLIDE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_collide |=> err_collide); // R7
    AST_COLLIDE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_collide) |-> (|(mask0 & mask1))); // R7
    AST_ACCESS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_access |=> err_access); // R9
endmodule

bind irq_steer_top irq_steer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask0       (mask_q[0]),
    .mask1       (mask_q[1]),
    .stat        (stat_q),
    .irq         (irq_o),
    .err_collide (err_collide),
    .err_access  (err_access)
);

// File: tb/sim_irq_steer_top.sv
module sim_irq_steer_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_M0 = 12'h0F0, A_M1 = 12'h1F0, A_ST = 12'h2F0, A_IN = 12'h3F0;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [31:0] src = '0, wdata = '0;
    logic [11:0] addr = '0;
    logic        we = 1'b0, re = 1'b0, cid = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  irq;
    logic        ecol, eacc;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    irq_steer_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
        .bus_re(re), .bus_wdata(wdata), .bus_cpu_id(cid), .bus_rdata(rdata),
        .irq_o(irq), .err_collide(ecol), .err_access(eacc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {op(1=read check), cpu id, addr, data, expected read}
    localparam int NV = 12;
    localparam logic [77:0] VEC [NV] = '{
        {1'b0, 1'b0, A_M0, 32'h8000_000F, 32'h0},
        {1'b1, 1'b0, A_M0, 32'h0,         32'h0000_000F},
        {1'b0, 1'b0, A_M0, 32'h0000_0005, 32'h0},
        {1'b1, 1'b0, A_M0, 32'h0,         32'h0000_000A},
        {1'b0, 1'b0, A_M1, 32'h8000_00F0, 32'h0},
        {1'b1, 1'b1, A_M1, 32'h0,         32'h0000_00F0},
        {1'b0, 1'b0, A_ST, 32'h8000_0022, 32'h0},
        {1'b1, 1'b0, A_ST, 32'h0,         32'h0000_0022},
        {1'b0, 1'b0, A_ST, 32'h0000_0002, 32'h0},
        {1'b1, 1'b0, A_ST, 32'h0,         32'h0000_0020},
        {1'b1, 1'b0, A_IN, 32'h0,         32'hA5C3_0F1E},
        {1'b1, 1'b1, A_IN, 32'h0,         32'hA7C3_0F1E}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk) begin addr = a; wdata = d; we = 1'b1; end
        @(posedge clk);
        @(negedge clk) we = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, input logic id, output logic [31:0] d);
        @(negedge clk) begin addr = a; cid = id; re = 1'b1; end
        @(posedge clk);
        @(negedge clk) begin re = 1'b0; d = rdata; end
    endtask

    function automatic string tag_of(input logic [11:0] a);
        if (a == A_ST) return "R3 status";
        if (a == A_IN) return "R8 info";
        return "R2 mask";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        do_reset();
        // R1 reset state
        chk("R1 irq", {30'h0, irq}, 32'h0);
        chk("R1 flags", {30'h0, ecol, eacc}, 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        bread(A_M0, 1'b0, rd); chk("R1 mask0", rd, 32'h0);
        bread(A_M1, 1'b0, rd); chk("R1 mask1", rd, 32'h0);
        bread(A_ST, 1'b0, rd); chk("R1 status", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][77]) begin
                bread(VEC[i][75:64], VEC[i][76], rd);
                chk(tag_of(VEC[i][75:64]), rd, VEC[i][31:0]);
            end else begin
                bwrite(VEC[i][75:64], VEC[i][63:32]);
            end
        end
        // status 0x20, mask0 0xA, mask1 0xF0: only processor 1 matches
        @(negedge clk);
        chk("R4 routing", {30'h0, irq}, 32'h2);
        chk("R7 no collide yet", {31'h0, ecol}, 32'h0);
        chk("R9 no access error yet", {31'h0, eacc}, 32'h0);

        // R4 registered timing: status becomes 0x28, bit 3 is in mask0
        bwrite(A_ST, 32'h8000_0008);
        chk("R4 irq0 not yet", {31'h0, irq[0]}, 32'h0);
        @(negedge clk);
        chk("R4 irq0 one cycle later", {31'h0, irq[0]}, 32'h1);

        // R3 bit 31 holds no state
        bwrite(A_ST, 32'hFFFF_FFFF);
        bread(A_ST, 1'b0, rd); chk("R3 set all", rd, 32'h7FFF_FFFF);
        bwrite(A_ST, 32'h7FFF_FFFF);
        bread(A_ST, 1'b0, rd); chk("R3 clear all", rd, 32'h0);
        @(negedge clk);
        chk("R4 both low", {30'h0, irq}, 32'h0);

        // R5 source edges, line bit 31 ignored
        @(negedge clk) src = 32'h8000_0008;
        repeat (5) @(negedge clk);
        bread(A_ST, 1'b0, rd); chk("R5 rise sets", rd, 32'h0000_0008);
        chk("R5 irq0 from source", {31'h0, irq[0]}, 32'h1);
        @(negedge clk) src = 32'h0;
        repeat (5) @(negedge clk);
        bread(A_ST, 1'b0, rd); chk("R5 fall clears", rd, 32'h0);
        chk("R5 irq0 released", {31'h0, irq[0]}, 32'h0);

        // R6 clearing write lands in the same cycle as the rising edge
        @(negedge clk) src = 32'h0000_0002;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) begin addr = A_ST; wdata = 32'h0000_0002; we = 1'b1; end
        @(posedge clk);
        @(negedge clk) we = 1'b0;
        bread(A_ST, 1'b0, rd); chk("R6 bus wins", rd, 32'h0);
        @(negedge clk) src = 32'h0;
        repeat (5) @(negedge clk);

        // R7 overlap: mask0 holds bit 1
        bwrite(A_M1, 32'h8000_0002);
        chk("R7 collide raised", {31'h0, ecol}, 32'h1);
        bwrite(A_M1, 32'h0000_0002);
        chk("R7 collide sticky", {31'h0, ecol}, 32'h1);

        // R10 read data holds between reads
        bread(A_M0, 1'b0, rd);
        repeat (3) @(negedge clk);
        chk("R10 rdata held", rdata, 32'h0000_000A);

        // R9 unlisted read
        bread(12'h7F0, 1'b0, rd);
        chk("R9 unlisted read zero", rd, 32'h0);
        chk("R9 unlisted flag", {31'h0, eacc}, 32'h1);

        // R9 write to information register after fresh reset
        do_reset();
        chk("R1 flags after reset", {30'h0, ecol, eacc}, 32'h0);
        bwrite(A_IN, 32'h1234_5678);
        chk("R9 info write flag", {31'h0, eacc}, 32'h1);
        bread(A_IN, 1'b0, rd); chk("R8 info unchanged", rd, 32'hA5C3_0F1E);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule